// File: doc/BRIEF.md
# Card Block-Range Erase Sequencer

This block runs a block-range erase on a memory card from the host side. A single `go` pulse captures a first and a last block address. The sequencer then issues three commands in a fixed order through a simple issue port: it tags the first address, tags the last address, then gives the erase order. It waits for a response to each command and keeps a minimum idle gap before the next one. After the erase response it waits until the card releases the data-line busy, and then it reports completion.

Serializing the commands, computing the CRC and parsing the responses all happen in a separate command engine. That engine receives a one-cycle `cmd_issue` strobe with an index and an argument. It reports back a good response on `rsp_valid` or an error response on `rsp_err`. The sequencer runs its own response window. It treats silence within that window as a timeout. Any fault ends the run with a coded error that stays visible until the next start.

Top module: `erase_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `running`, `cmd_issue`, `done`, `err` and `err_code` are all 0.
- R2: A `go` taken while idle produces exactly three commands, in this order: index 32 with the captured first address, index 33 with the captured last address, and index 38 with argument 0. Both addresses are captured at the `go` edge. Changes on the address inputs after that edge have no effect.
- R3: `cmd_issue` is a one-cycle pulse. The first command is issued on the clock edge after the one that takes `go`. Each later command is issued on the GAP_CYC-th clock edge after the edge that accepts the previous response.
- R4: A response is accepted on any of the RSP_MAX clock edges that follow the edge ending the `cmd_issue` pulse. If no response arrives by the last of these edges, the run aborts with a timeout.
- R5: `rsp_err` sampled during the response window aborts the run at once, with no further commands.
- R6: `err_code` encoding: bit 2 is 1 for a timeout and 0 for an error response. Bits 1:0 hold 1, 2 or 3 for the first-tag, last-tag or erase command, and hold 0 for the busy wait.
- R7: After the erase response is accepted, `done` rises one cycle after the first edge, from the next edge onward, that samples `dat_busy` low. In that case `err` is 0.
- R8: If `dat_busy` is still high on the BUSY_MAX-th edge of the busy wait, the run aborts with `err_code` = 3'b100.
- R9: `go` has no effect while `running` is 1. The command order and the captured addresses are unchanged.
- R10: `done` is a one-cycle pulse at the end of every run, whether it succeeds or aborts. `err` and `err_code` hold their values until the next `go` is taken.
- R11: When a terminal event and its limit fall on the same edge, the event wins. A response on the last window edge is accepted. A busy release on the BUSY_MAX-th edge gives success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, taken only while idle |
| first_addr | input | AW | First block address of the range |
| last_addr | input | AW | Last block address of the range |
| running | output | 1 | High while a run is in progress |
| cmd_issue | output | 1 | One-cycle request to the command engine |
| cmd_idx | output | 6 | Command index for the current step |
| cmd_arg | output | AW | Command argument for the current step |
| rsp_valid | input | 1 | Good response received |
| rsp_err | input | 1 | Error response received |
| dat_busy | input | 1 | Card holds the data line busy |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run aborted |
| err_code | output | 3 | Abort cause and step |

## Verification
Two pairs of events can fall on the same edge: a response and the window timeout, and a busy release and the busy limit. In each pair, one event ends the step normally and the other ends it with an abort. The bench sweeps the response delay over every edge of the window for each of the three commands, up to and including the last edge. It also sweeps the busy length from one edge to one edge past the limit. From the delay alone, the bench predicts whether the run finishes cleanly or aborts. It checks that prediction, and the exact cycle of `done`, against the design.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ISSUE = 3'd1,
        S_WAIT  = 3'd2,
        S_GAP   = 3'd3,
        S_BUSY  = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        STEP_FIRST = 2'd0,
        STEP_LAST  = 2'd1,
        STEP_ERASE = 2'd2
    } seq_step_e;

    localparam logic [5:0] IDX_TAG_FIRST = 6'd32;
    localparam logic [5:0] IDX_TAG_LAST  = 6'd33;
    localparam logic [5:0] IDX_ERASE     = 6'd38;

    localparam logic [2:0] CODE_BUSY_TMO = 3'b100;

endpackage

// File: rtl/erase_cmd_sel.sv
module erase_cmd_sel
    import erase_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  seq_step_e         step,
    input  logic [AW-1:0]     first_q,
    input  logic [AW-1:0]     last_q,
    output logic [5:0]        cmd_idx,
    output logic [AW-1:0]     cmd_arg
);

    always_comb begin
        case (step)
            STEP_FIRST: begin
                cmd_idx = IDX_TAG_FIRST;
                cmd_arg = first_q;
            end
            STEP_LAST: begin
                cmd_idx = IDX_TAG_LAST;
                cmd_arg = last_q;
            end
            default: begin
                cmd_idx = IDX_ERASE;
                cmd_arg = '0;
            end
        endcase
    end

endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
    import erase_seq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RSP_MAX  = 64,
    parameter int GAP_CYC  = 8,
    parameter int BUSY_MAX = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] first_in,
    input  logic [AW-1:0] last_in,
    input  logic          rsp_valid,
    input  logic          rsp_err,
    input  logic          dat_busy,
    output logic          issue,
    output seq_step_e     step,
    output logic [AW-1:0] first_q,
    output logic [AW-1:0] last_q,
    output logic          running,
    output logic          done,
    output logic          err,
    output logic [2:0]    err_code
);

    localparam int LIM_A  = (RSP_MAX > GAP_CYC) ? RSP_MAX : GAP_CYC;
    localparam int LIM    = (LIM_A > BUSY_MAX) ? LIM_A : BUSY_MAX;
    localparam int CW     = $clog2(LIM + 1);
    localparam int GW     = $clog2(GAP_CYC + 1);

    typedef struct packed {
        seq_st_e       st;
        seq_step_e     step;
        logic [CW-1:0] cnt;
        logic [AW-1:0] first;
        logic [AW-1:0] last;
        logic          done;
        logic          err;
        logic [2:0]    code;
    } seq_reg_t;

    seq_reg_t r_q, r_d;
    logic [1:0] step_num;

    assign step_num = 2'(r_q.step) + 2'd1;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (go) begin
                    r_d.st    = S_ISSUE;
                    r_d.step  = STEP_FIRST;
                    r_d.first = first_in;
                    r_d.last  = last_in;
                    r_d.err   = 1'b0;
                    r_d.code  = 3'b000;
                end
            end
            S_ISSUE: begin
                r_d.st  = S_WAIT;
                r_d.cnt = '0;
            end
            S_WAIT: begin
                if (rsp_err) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.code = {1'b0, step_num};
                end else if (rsp_valid) begin
                    r_d.cnt = '0;
                    if (r_q.step == STEP_ERASE) begin
                        r_d.st = S_BUSY;
                    end else begin
                        r_d.st   = S_GAP;
                        r_d.step = seq_step_e'(step_num);
                    end
                end else if (r_q.cnt == CW'(RSP_MAX - 1)) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.code = {1'b1, step_num};
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_GAP: begin
                if (r_q.cnt == CW'(GAP_CYC - 1)) begin
                    r_d.st = S_ISSUE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_BUSY: begin
                if (!dat_busy) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                end else if (r_q.cnt == CW'(BUSY_MAX - 1)) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.code = CODE_BUSY_TMO;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                r_d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, step: STEP_FIRST, cnt: '0, first: '0,
                     last: '0, done: 1'b0, err: 1'b0, code: 3'b000};
        end else begin
            r_q <= r_d;
        end
    end

    assign issue    = (r_q.st == S_ISSUE);
    assign running  = (r_q.st != S_IDLE);
    assign step     = r_q.step;
    assign first_q  = r_q.first;
    assign last_q   = r_q.last;
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign err_code = r_q.code;

    // Guard: cycles since the last accepted good response, saturating.
    logic [GW-1:0] gap_seen_q;
    logic          rsp_take;
    assign rsp_take = (r_q.st == S_WAIT) && rsp_valid && !rsp_err;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_seen_q <= '0;
        end else if (rsp_take) begin
            gap_seen_q <= '0;
        end else if (gap_seen_q != GW'(GAP_CYC)) begin
            gap_seen_q <= gap_seen_q + 1'b1;
        end
    end

    AST_ISSUE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !issue); // R3

    AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && step != STEP_FIRST) |-> (gap_seen_q == GW'(GAP_CYC))); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WAIT) |-> (r_q.cnt < CW'(RSP_MAX))); // R4

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_BUSY) |-> (r_q.cnt < CW'(BUSY_MAX))); // R8

    AST_ERR_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 3'b000)); // R6

    AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && go) |=> ($stable(first_q) && $stable(last_q))); // R9

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !go) |=> ($stable(err) && $stable(err_code))); // R10

endmodule

// File: rtl/erase_seq.sv
module erase_seq
    import erase_seq_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RSP_MAX  = 64,
    parameter int GAP_CYC  = 8,
    parameter int BUSY_MAX = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic          running,
    output logic          cmd_issue,
    output logic [5:0]    cmd_idx,
    output logic [AW-1:0] cmd_arg,
    input  logic          rsp_valid,
    input  logic          rsp_err,
    input  logic          dat_busy,
    output logic          done,
    output logic          err,
    output logic [2:0]    err_code
);

    seq_step_e     step_w;
    logic [AW-1:0] first_w;
    logic [AW-1:0] last_w;

    erase_seq_fsm #(
        .AW       (AW),
        .RSP_MAX  (RSP_MAX),
        .GAP_CYC  (GAP_CYC),
        .BUSY_MAX (BUSY_MAX)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .first_in  (first_addr),
        .last_in   (last_addr),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .dat_busy  (dat_busy),
        .issue     (cmd_issue),
        .step      (step_w),
        .first_q   (first_w),
        .last_q    (last_w),
        .running   (running),
        .done      (done),
        .err       (err),
        .err_code  (err_code)
    );

    erase_cmd_sel #(
        .AW (AW)
    ) u_sel (
        .step    (step_w),
        .first_q (first_w),
        .last_q  (last_w),
        .cmd_idx (cmd_idx),
        .cmd_arg (cmd_arg)
    );

    AST_ERASE_ARG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && cmd_idx == IDX_ERASE) |-> (cmd_arg == '0)); // R2

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !running); // R10

endmodule

// File: tb/erase_seq_tb.sv
module erase_seq_tb;

    localparam int AW       = 32;
    localparam int RSP_MAX  = 64;
    localparam int GAP_CYC  = 8;
    localparam int BUSY_MAX = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic [AW-1:0] a_first = '0;
    logic [AW-1:0] a_last = '0;
    logic          rsp_valid = 1'b0;
    logic          rsp_err = 1'b0;
    logic          dat_busy = 1'b0;
    logic          running, cmd_issue, done, err;
    logic [5:0]    cmd_idx;
    logic [AW-1:0] cmd_arg;
    logic [2:0]    err_code;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    erase_seq #(
        .AW (AW), .RSP_MAX (RSP_MAX), .GAP_CYC (GAP_CYC), .BUSY_MAX (BUSY_MAX)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .go (go),
        .first_addr (a_first), .last_addr (a_last),
        .running (running), .cmd_issue (cmd_issue),
        .cmd_idx (cmd_idx), .cmd_arg (cmd_arg),
        .rsp_valid (rsp_valid), .rsp_err (rsp_err), .dat_busy (dat_busy),
        .done (done), .err (err), .err_code (err_code)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_idx(input int k);
        return (k == 0) ? 32 : ((k == 1) ? 33 : 38);
    endfunction

    // fstep: 0 none, 1..3 command step that faults; ftmo: fault is a timeout
    task automatic run_case(input logic [AW-1:0] sa, input logic [AW-1:0] ea,
                            input int d0, input int d1, input int d2,
                            input int fstep, input bit ftmo, input int blen,
                            input bit poke_go);
        int since;
        int dl;
        longint ea_exp;
        since = 0;
        @(negedge clk);
        go = 1'b1; a_first = sa; a_last = ea;
        @(negedge clk);
        go = 1'b0; a_first = ~sa; a_last = ~ea;
        chk(err == 1'b0, "R10 err cleared by go", err, 0);
        chk(running == 1'b1, "R9 running after go", running, 1);
        for (int k = 0; k < 3; k++) begin
            if (k > 0) begin
                while (!cmd_issue && since < 300) begin
                    @(negedge clk);
                    since++;
                end
                chk(since == GAP_CYC + 1, "R3 gap before command", since, GAP_CYC + 1);
            end else begin
                chk(cmd_issue == 1'b1, "R3 first issue after go", cmd_issue, 1);
            end
            ea_exp = (k == 0) ? longint'(sa) : ((k == 1) ? longint'(ea) : 0);
            chk(cmd_idx == 6'(exp_idx(k)), "R2 command index order", cmd_idx, exp_idx(k));
            chk(cmd_arg == AW'(ea_exp), "R2 command argument", cmd_arg, ea_exp);
            if (poke_go && k == 1) begin
                go = 1'b1; a_first = 32'hDEAD_BEEF; a_last = 32'hBEEF_DEAD;
            end
            @(negedge clk);
            go = 1'b0;
            chk(cmd_issue == 1'b0, "R3 issue is one cycle", cmd_issue, 0);
            dl = (k == 0) ? d0 : ((k == 1) ? d1 : d2);
            if (fstep == k + 1 && ftmo) begin
                repeat (RSP_MAX - 1) @(negedge clk);
                chk(done == 1'b0, "R4 no early timeout", done, 0);
                @(negedge clk);
                chk(done == 1'b1, "R4 timeout ends run", done, 1);
                chk(err == 1'b1, "R4 timeout flags error", err, 1);
                chk(err_code == {1'b1, 2'(k + 1)}, "R6 timeout code", err_code, {1'b1, 2'(k + 1)});
                @(negedge clk);
                chk(done == 1'b0, "R10 done pulse", done, 0);
                repeat (5) @(negedge clk);
                chk(err == 1'b1, "R10 err held", err, 1);
                chk(cmd_issue == 1'b0 && running == 1'b0, "R5 no command after abort", cmd_issue, 0);
                return;
            end
            if (dl > 1) repeat (dl - 1) @(negedge clk);
            if (fstep == k + 1) begin
                rsp_err = 1'b1;
                @(negedge clk);
                rsp_err = 1'b0;
                chk(done == 1'b1, "R5 error response ends run", done, 1);
                chk(err_code == {1'b0, 2'(k + 1)}, "R6 error code", err_code, {1'b0, 2'(k + 1)});
                @(negedge clk);
                chk(done == 1'b0, "R10 done pulse", done, 0);
                repeat (GAP_CYC + 3) @(negedge clk);
                chk(cmd_issue == 1'b0 && running == 1'b0, "R5 no command after abort", running, 0);
                chk(err == 1'b1, "R10 err held", err, 1);
                return;
            end
            rsp_valid = 1'b1;
            if (k == 2) dat_busy = 1'b1;
            @(negedge clk);
            rsp_valid = 1'b0;
            if (dl == RSP_MAX)
                chk(done == 1'b0 && err == 1'b0, "R11 last-edge response accepted", err, 0);
            since = 1;
        end
        if (blen <= BUSY_MAX) begin
            if (blen > 1) repeat (blen - 1) @(negedge clk);
            chk(done == 1'b0, "R7 no done while busy", done, 0);
            dat_busy = 1'b0;
            @(negedge clk);
            chk(done == 1'b1, "R7 done after busy release", done, 1);
            chk(err == 1'b0, blen == BUSY_MAX ? "R11 release on limit edge" : "R7 clean end", err, 0);
        end else begin
            repeat (BUSY_MAX - 1) @(negedge clk);
            chk(done == 1'b0, "R8 no early busy timeout", done, 0);
            @(negedge clk);
            dat_busy = 1'b0;
            chk(done == 1'b1 && err == 1'b1, "R8 busy timeout ends run", err, 1);
            chk(err_code == 3'b100, "R8 busy timeout code", err_code, 3'b100);
        end
        @(negedge clk);
        chk(done == 1'b0, "R10 done pulse", done, 0);
        chk(running == 1'b0, "R10 idle after run", running, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        go = 1'b1;
        repeat (3) @(negedge clk);
        chk(running == 1'b0 && cmd_issue == 1'b0, "R1 reset idle", running, 0);
        chk(done == 1'b0 && err == 1'b0 && err_code == 3'b000, "R1 reset flags", err_code, 0);
        go = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(running == 1'b0 && done == 1'b0, "R1 idle after reset", running, 0);

        run_case(32'h0000_0000, 32'hFFFF_FFFF, 2, 2, 2, 0, 1'b0, 3, 1'b0);
        run_case(32'h1234_5678, 32'h9ABC_DEF0, 1, 1, 1, 0, 1'b0, 1, 1'b0);
        run_case(32'hA5A5_A5A5, 32'h5A5A_5A5A, 5, 9, 3, 0, 1'b0, 0, 1'b0);
        // R9: go pulsed mid-run
        run_case(32'h0000_0100, 32'h0000_01FF, 3, 4, 5, 0, 1'b0, 2, 1'b1);

        // R4, R11: every delay in the window for every command
        for (int k = 0; k < 3; k++) begin
            for (int d = 1; d <= RSP_MAX; d++) begin
                run_case(32'h10 + 32'(d), 32'h800 + 32'(k),
                         (k == 0) ? d : 2, (k == 1) ? d : 2, (k == 2) ? d : 2,
                         0, 1'b0, 1, 1'b0);
            end
        end

        // R5, R6: error response and timeout at each step
        for (int s = 1; s <= 3; s++) begin
            run_case(32'h40, 32'h80, 3, 3, 3, s, 1'b0, 1, 1'b0);
            run_case(32'h41, 32'h81, 3, 3, 3, s, 1'b1, 1, 1'b0);
        end

        // R7, R8, R11: busy length sweep across the limit
        for (int l = 1; l <= BUSY_MAX + 1; l++) begin
            run_case(32'h200, 32'h2FF, 2, 2, 2, 0, 1'b0, l, 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule